// File: doc/BRIEF.md
# Bus-Side Memory Map Decoder

This block sits between an 8-bit processor bus and two on-board stores: a 4 KiB read-only store and a 2 KiB read/write store. It turns the bus status line and the active-low read and write lines into memory read and write strobes. It decodes the upper address bits into eight active-low selects through a gated one-of-eight decoder. It also returns the byte of whichever store is selected on the read data bus.

The decoder treats the status line `io_m` as an active-low enable, so selects appear only for memory cycles. It treats address bit 15 as a second active-low enable. Its active-high enable is tied on. Select 0 covers 0000H-0FFFH and drives the read-only store. Select 1 covers 1000H-1FFFH and drives the read/write store. The read/write store does not look at address bit 11, so its 2 KiB of contents appear twice in that window: once at 1000H and again at 1800H. The read-only contents are computed from the address, so the store needs no programming port.

Top module: `memmap_decoder`

## Requirements
- R1: When `io_m`=0 and `addr[15]`=0, exactly one bit of `sel_n` is low, namely bit number `addr[14:12]` (bit 0 = A12 on the least significant decoder input).
- R2: When `io_m`=1 or `addr[15]`=1, all eight bits of `sel_n` are high.
- R3: `memr_n` is low exactly when `io_m`=0 and `rd_n`=0. `memw_n` is low exactly when `io_m`=0 and `wr_n`=0.
- R4: A memory read in 0000H-0FFFH returns the read-only byte `addr[7:0] ^ {addr[11:8],addr[11:8]} ^ 8'h5A`, combinationally in the same cycle.
- R5: A rising clock edge with `memw_n` low and the address in 1000H-1FFFH stores `wdata` at index `addr[10:0]`. A later memory read of that address returns the stored byte combinationally.
- R6: Two addresses in 1000H-1FFFH that differ only in bit 11 reach the same read/write byte.
- R7: `rdata` is FFH whenever `memr_n` is high, or no store is selected (addresses 2000H-FFFFH).
- R8: A write strobe in 0000H-0FFFH changes neither the read-only contents nor any read/write byte.
- R9: A cycle with `io_m`=1 writes no read/write byte and returns FFH on `rdata`.
- R10: While `rst_n` is low, no write reaches the read/write store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; store writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data from the processor |
| rd_n | input | 1 | Active-low read line |
| wr_n | input | 1 | Active-low write line |
| io_m | input | 1 | Cycle type: 0 memory, 1 I/O |
| rdata | output | 8 | Read data to the processor; FFH when nothing drives it |
| memr_n | output | 1 | Active-low memory read strobe |
| memw_n | output | 1 | Active-low memory write strobe |
| sel_n | output | 8 | Active-low decoder outputs, one per 4 KiB slot |

## Verification
The strobes, the selects and every read result are combinational, so they are due in the same cycle as the bus inputs. The bench drives each bus state on the falling edge and samples two nanoseconds later, before the next rising edge. A write takes effect at the first rising edge after its strobe is driven. Its effect is therefore checked only by a read vector driven on the following falling edge. Alias, read-only-write and I/O-cycle checks read back the affected read/write bytes through the bus to show that nothing changed.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ROM_AW = 12,
  parameter int RAM_AW = 11,
  parameter int ROM_SLOT = 0,
  parameter int RAM_SLOT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          io_m,
  output logic [DW-1:0] rdata,
  output logic          memr_n,
  output logic          memw_n,
  output logic [7:0]    sel_n
);

  localparam int SEL_LO   = ROM_AW;
  localparam int RAM_SIZE = 1 << RAM_AW;
  localparam logic [DW-1:0] FLOAT = '1;

  logic       en_low1, en_low2, en_high;
  logic [2:0] slot;
  logic [DW-1:0] ram [RAM_SIZE];
  logic [DW-1:0] rom_q, ram_q;

  assign memr_n = ~(~io_m & ~rd_n);
  assign memw_n = ~(~io_m & ~wr_n);

  assign en_low1 = io_m;
  assign en_low2 = addr[AW-1];
  assign en_high = 1'b1;
  assign slot    = addr[SEL_LO+2:SEL_LO];

  generate
    for (genvar i = 0; i < 8; i++) begin : g_dec
      assign sel_n[i] = ~(~en_low1 & ~en_low2 & en_high & (slot == 3'(i)));
    end
  endgenerate

  function automatic logic [DW-1:0] rom_byte(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign rom_q = rom_byte(addr[ROM_AW-1:0]);
  assign ram_q = ram[addr[RAM_AW-1:0]];

  always_ff @(posedge clk)
    if (rst_n && !memw_n && !sel_n[RAM_SLOT])
      ram[addr[RAM_AW-1:0]] <= wdata;

  assign rdata = memr_n             ? FLOAT :
                 !sel_n[ROM_SLOT]   ? rom_q :
                 !sel_n[RAM_SLOT]   ? ram_q : FLOAT;

  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);
  a_r2_io_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (io_m || addr[AW-1]) |-> (sel_n == 8'hFF));
  a_r3_io_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (memr_n && memw_n));
  a_r7_float: assert property (@(posedge clk) disable iff (!rst_n)
    (memr_n || (sel_n[ROM_SLOT] && sel_n[RAM_SLOT])) |-> (rdata == FLOAT));
  a_r9_io_float: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (rdata == FLOAT));

endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, io_m = 1'b1;
  logic [7:0]  rdata, sel_n;
  logic        memr_n, memw_n;

  int checks = 0, bad = 0;
  logic [7:0] ram_m [2048];

  always #5 clk = ~clk;

  memmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_n(rd_n),
    .wr_n(wr_n), .io_m(io_m), .rdata(rdata), .memr_n(memr_n),
    .memw_n(memw_n), .sel_n(sel_n));

  // {io_m, rd_n, wr_n, addr, wdata}
  localparam logic [26:0] VEC [18] = '{
    {1'b0, 1'b0, 1'b1, 16'h0000, 8'h00},  // R4 rom low
    {1'b0, 1'b0, 1'b1, 16'h0FFF, 8'h00},  // R4 rom top
    {1'b0, 1'b0, 1'b1, 16'h0A5C, 8'h00},  // R4 rom mid
    {1'b0, 1'b1, 1'b0, 16'h1234, 8'h3C},  // R5 write
    {1'b0, 1'b0, 1'b1, 16'h1234, 8'h00},  // R5 read back
    {1'b0, 1'b0, 1'b1, 16'h1A34, 8'h00},  // R6 alias
    {1'b0, 1'b1, 1'b0, 16'h1FFF, 8'hC7},  // R6 write at mirror top
    {1'b0, 1'b0, 1'b1, 16'h17FF, 8'h00},  // R6 read low copy
    {1'b0, 1'b1, 1'b0, 16'h0234, 8'h99},  // R8 rom write
    {1'b0, 1'b0, 1'b1, 16'h0234, 8'h00},  // R8 rom intact
    {1'b0, 1'b0, 1'b1, 16'h1234, 8'h00},  // R8 ram intact
    {1'b1, 1'b0, 1'b1, 16'h1234, 8'h00},  // R9 io read
    {1'b1, 1'b1, 1'b0, 16'h1234, 8'h55},  // R9 io write
    {1'b0, 1'b0, 1'b1, 16'h1234, 8'h00},  // R9 ram intact
    {1'b0, 1'b0, 1'b1, 16'h2000, 8'h00},  // R1 slot 2
    {1'b0, 1'b0, 1'b1, 16'h7000, 8'h00},  // R1 slot 7
    {1'b0, 1'b0, 1'b1, 16'h9000, 8'h00},  // R2 a15 high
    {1'b0, 1'b1, 1'b1, 16'h1234, 8'h00}   // R7 rd idle
  };

  function automatic logic [7:0] exp_sel(input logic [15:0] a, input logic io);
    return (io || a[15]) ? 8'hFF : ~(8'h01 << a[14:12]);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic io,
                                        input logic rdn);
    if (io || rdn) return 8'hFF;
    if (a[15:12] == 4'h0) return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    if (a[15:12] == 4'h1) return ram_m[a[10:0]];
    return 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h addr=%h", tag, act, exp, addr);
    end
  endtask

  task automatic check_bus(input string tag);
    check({tag, " R1/R2 sel"}, sel_n, exp_sel(addr, io_m));
    check("R3 memr_n", {7'd0, memr_n}, {7'd0, ~(~io_m & ~rd_n)});
    check("R3 memw_n", {7'd0, memw_n}, {7'd0, ~(~io_m & ~wr_n)});
    check({tag, " rdata"}, rdata, exp_rd(addr, io_m, rd_n));
  endtask

  initial begin
    #1ms;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    check("R10 reset sel", sel_n, 8'hFF);
    check("R10 reset rdata", rdata, 8'hFF);
    check("R10 reset strobes", {6'd0, memr_n, memw_n}, 8'h03);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      {io_m, rd_n, wr_n, addr, wdata} = VEC[i];
      #2;
      check_bus($sformatf("vec%0d", i));
      if (!io_m && !wr_n && addr[15:12] == 4'h1) ram_m[addr[10:0]] = wdata;
    end

    // R10: write under reset is blocked
    @(negedge clk);
    {io_m, rd_n, wr_n, addr, wdata} = {1'b0, 1'b1, 1'b0, 16'h1300, 8'h11};
    ram_m[11'h300] = 8'h11;
    @(negedge clk);
    rst_n = 1'b0;
    wdata = 8'hAA;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    {io_m, rd_n, wr_n} = 3'b001;
    #2;
    check("R10 write blocked in reset", rdata, 8'h11);

    // R6: alias from the upper copy, byte by byte
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      {io_m, rd_n, wr_n, addr, wdata} = {1'b0, 1'b1, 1'b0, 16'h1800 + 16'(k), 8'(8'hE0 + k)};
      @(negedge clk);
      {io_m, rd_n, wr_n} = 3'b001;
      addr = 16'h1000 + 16'(k);
      #2;
      check("R6 alias readback", rdata, 8'(8'hE0 + k));
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule